// File: doc/BRIEF.md
# Page-Boundary Program Splitter

This block turns one flash program request, given as a start byte address and a byte count, into a run of page-program commands. None of these commands crosses a page boundary. The first command runs only up to the next page boundary. Each later command covers one whole page, except the last, which carries only the bytes that remain.

Every chunk goes through the same four steps. The block asks a command sequencer for a write-enable and then asks a status poller to wait until the write-enable latch is set. It then asks the sequencer for the quad-input program command. That command sends the opcode on one line, and the 24-bit address and the data on four lines, with no dummy cycles. While the command runs, the block passes exactly that chunk's bytes from its data input to its data output. Last, it asks the poller to wait until the busy bit clears.

Both helpers use a level request held until a one-cycle done, which comes with an error flag. An error on any step stops the whole request. A request of zero length finishes at once and issues no commands.

Top module: `page_prog_splitter`

## Requirements
- R1: Every program command has a non-zero length, and its address offset within the page plus its length is at most PAGE_BYTES.
- R2: The first program command uses the start address and has length min(len, PAGE_BYTES - (addr mod PAGE_BYTES)).
- R3: Each later program command starts where the previous one ended. Its length is PAGE_BYTES, or the bytes still left if that is fewer. The lengths sum to the requested length.
- R4: Each chunk issues, in this order: cmd_kind=0 (write-enable), poll_kind=0 (wait for the latch to be set), cmd_kind=1 (quad program with data), poll_kind=1 (wait for busy to clear).
- R5: A request line stays high, with stable kind, address and length, until its done arrives. cmd_req and poll_req are never high together.
- R6: Bytes pass from in_* to out_* only while a program command is requested. Exactly cmd_len bytes pass per command, in order and unchanged.
- R7: A done that carries an error aborts the request. No further requests are made, and done and error are high the next cycle.
- R8: A zero-length request raises done with error low in the cycle after it is accepted, and makes no requests.
- R9: busy is high from acceptance until done. A req_valid seen while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start pulse, taken when not busy |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | LEN_W | Total byte count |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Valid with done: request aborted |
| cmd_req | output | 1 | Sequencer request, held until cmd_done |
| cmd_kind | output | 1 | 0 write-enable, 1 quad program |
| cmd_addr | output | ADDR_W | Program address |
| cmd_len | output | LEN_W | Program byte count |
| cmd_done | input | 1 | Sequencer finished |
| cmd_err | input | 1 | Sequencer failure, valid with cmd_done |
| poll_req | output | 1 | Poller request, held until poll_done |
| poll_kind | output | 1 | 0 wait latch set, 1 wait busy clear |
| poll_done | input | 1 | Poller finished |
| poll_err | input | 1 | Poller failure or timeout, valid with poll_done |
| in_data | input | DATA_W | Source byte |
| in_valid | input | 1 | Source byte valid |
| in_ready | output | 1 | Source byte taken |
| out_data | output | DATA_W | Byte to the sequencer |
| out_valid | output | 1 | Byte to the sequencer valid |
| out_ready | input | 1 | Sequencer takes byte |

## Verification
The assertions check the cycle-level rules on every cycle: no program command crosses a page, requests are held and never overlap, the four steps run in order, bytes move only during a program command and their count matches its length, and an error or a zero length leads to done in the next cycle. Only the bench's sweep over start offsets and lengths can show that the chunk addresses and lengths follow the split arithmetic, that the bytes arrive in order with the right total, and that a request made while busy leaves the commands unchanged. The bench also injects a write-enable-latch timeout and a program failure on the second chunk. These show how many steps run before the abort.

// File: rtl/psplit_pkg.sv
`timescale 1ns/1ps
package psplit_pkg;
  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_WEN   = 3'd1,
    S_LATCH = 3'd2,
    S_PROG  = 3'd3,
    S_READY = 3'd4,
    S_FIN   = 3'd5
  } psplit_state_t;

  localparam logic CMD_WEN    = 1'b0;
  localparam logic CMD_PROG   = 1'b1;
  localparam logic POLL_LATCH = 1'b0;
  localparam logic POLL_CLEAR = 1'b1;
endpackage

// File: rtl/psplit_chunk.sv
`timescale 1ns/1ps
module psplit_chunk #(
  parameter int ADDR_W     = 24,
  parameter int LEN_W      = 16,
  parameter int PAGE_BYTES = 256
) (
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [LEN_W-1:0]  remain,
  output logic [LEN_W-1:0]  chunk,
  output logic              last
);
  localparam int OFF_W = $clog2(PAGE_BYTES);
  localparam int RW    = OFF_W + 1;
  localparam int CW    = (LEN_W > RW) ? LEN_W : RW;

  function automatic logic [CW-1:0] room_of(input logic [ADDR_W-1:0] a);
    logic [RW-1:0] r;
    r = RW'(PAGE_BYTES) - {1'b0, a[OFF_W-1:0]};
    return CW'(r);
  endfunction

  logic [CW-1:0] room_w;
  logic [CW-1:0] rem_w;

  always_comb begin
    room_w = room_of(cur_addr);
    rem_w  = CW'(remain);
    last   = (rem_w <= room_w);
    chunk  = last ? remain : LEN_W'(room_w);
  end
endmodule

// File: rtl/psplit_gate.sv
`timescale 1ns/1ps
module psplit_gate #(
  parameter int LEN_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic [LEN_W-1:0]  chunk_len,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              xfer
);
  logic [LEN_W-1:0] sent;
  logic             open_w;

  assign open_w    = active && (sent < chunk_len);
  assign out_valid = open_w && in_valid;
  assign in_ready  = open_w && out_ready;
  assign out_data  = in_data;
  assign xfer      = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n || !active) sent <= '0;
    else if (xfer)         sent <= sent + 1'b1;
  end
endmodule

// File: rtl/page_prog_splitter.sv
`timescale 1ns/1ps
module page_prog_splitter
  import psplit_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int LEN_W      = 16,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic              cmd_req,
  output logic              cmd_kind,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [LEN_W-1:0]  cmd_len,
  input  logic              cmd_done,
  input  logic              cmd_err,
  output logic              poll_req,
  output logic              poll_kind,
  input  logic              poll_done,
  input  logic              poll_err,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  input  logic              out_ready
);
  psplit_state_t    state, state_nx;
  logic [ADDR_W-1:0] cur_addr;
  logic [LEN_W-1:0]  remain;
  logic [LEN_W-1:0]  chunk;
  logic              last_chunk;
  logic              err_q;

  // named internal events
  logic ev_accept, ev_fail, ev_adv, ev_xfer, step_done;

  psplit_chunk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES)) u_chunk (
    .cur_addr(cur_addr), .remain(remain), .chunk(chunk), .last(last_chunk)
  );

  psplit_gate #(.LEN_W(LEN_W), .DATA_W(DATA_W)) u_gate (
    .clk(clk), .rst_n(rst_n), .active(state == S_PROG), .chunk_len(chunk),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
    .xfer(ev_xfer)
  );

  assign cmd_req   = (state == S_WEN) || (state == S_PROG);
  assign cmd_kind  = (state == S_PROG) ? CMD_PROG : CMD_WEN;
  assign cmd_addr  = cur_addr;
  assign cmd_len   = chunk;
  assign poll_req  = (state == S_LATCH) || (state == S_READY);
  assign poll_kind = (state == S_READY) ? POLL_CLEAR : POLL_LATCH;

  assign busy  = (state != S_IDLE);
  assign done  = (state == S_FIN);
  assign error = done && err_q;

  assign ev_accept = req_valid && (state == S_IDLE);
  assign step_done = (cmd_req && cmd_done) || (poll_req && poll_done);
  assign ev_fail   = (cmd_req && cmd_done && cmd_err) || (poll_req && poll_done && poll_err);
  assign ev_adv    = (state == S_READY) && poll_done && !poll_err;

  always_comb begin
    state_nx = state;
    unique case (state)
      S_IDLE:  if (ev_accept) state_nx = (req_len == '0) ? S_FIN : S_WEN;
      S_WEN:   if (step_done) state_nx = ev_fail ? S_FIN : S_LATCH;
      S_LATCH: if (step_done) state_nx = ev_fail ? S_FIN : S_PROG;
      S_PROG:  if (step_done) state_nx = ev_fail ? S_FIN : S_READY;
      S_READY: if (step_done) state_nx = (ev_fail || last_chunk) ? S_FIN : S_WEN;
      S_FIN:   state_nx = S_IDLE;
      default: state_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cur_addr <= '0;
      remain   <= '0;
      err_q    <= 1'b0;
    end else begin
      state <= state_nx;
      if (ev_accept) begin
        cur_addr <= req_addr;
        remain   <= req_len;
        err_q    <= 1'b0;
      end else begin
        if (ev_fail) err_q <= 1'b1;
        if (ev_adv) begin
          cur_addr <= cur_addr + ADDR_W'(chunk);
          remain   <= remain - chunk;
        end
      end
    end
  end
endmodule

// File: rtl/psplit_checker.sv
`timescale 1ns/1ps
module psplit_checker #(
  parameter int ADDR_W     = 24,
  parameter int LEN_W      = 16,
  parameter int PAGE_BYTES = 256
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [LEN_W-1:0]  req_len,
  input logic              busy,
  input logic              done,
  input logic              error,
  input logic              cmd_req,
  input logic              cmd_kind,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic [LEN_W-1:0]  cmd_len,
  input logic              cmd_done,
  input logic              cmd_err,
  input logic              poll_req,
  input logic              poll_kind,
  input logic              poll_done,
  input logic              poll_err,
  input logic              out_valid,
  input logic              out_ready
);
  localparam int OFF_W = $clog2(PAGE_BYTES);

  logic [LEN_W-1:0] seen_bytes;
  logic [LEN_W-1:0] bytes_now;
  logic [1:0]       last_step;
  logic             prog_on;
  int               span;

  assign prog_on   = cmd_req && cmd_kind;
  assign bytes_now = seen_bytes + LEN_W'(out_valid && out_ready);
  assign span      = int'(cmd_addr[OFF_W-1:0]) + int'(cmd_len);

  always_ff @(posedge clk) begin
    if (!rst_n || !prog_on) seen_bytes <= '0;
    else if (out_valid && out_ready) seen_bytes <= seen_bytes + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) last_step <= 2'd3;
    else if (cmd_req && cmd_done)   last_step <= cmd_kind ? 2'd2 : 2'd0;
    else if (poll_req && poll_done) last_step <= poll_kind ? 2'd3 : 2'd1;
  end

  a_r1_page_bound: assert property (@(posedge clk) disable iff (!rst_n)
    prog_on |-> (cmd_len != '0) && (span <= PAGE_BYTES));

  a_r4_prog_after_latch: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog_on) |-> last_step == 2'd1);

  a_r4_latch_after_wen: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(poll_req) && !poll_kind |-> last_step == 2'd0);

  a_r4_clear_after_prog: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(poll_req) && poll_kind |-> last_step == 2'd2);

  a_r5_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_req && !cmd_done |=> cmd_req && $stable(cmd_kind) && $stable(cmd_addr) && $stable(cmd_len));

  a_r5_poll_hold: assert property (@(posedge clk) disable iff (!rst_n)
    poll_req && !poll_done |=> poll_req && $stable(poll_kind));

  a_r5_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_req && poll_req));

  a_r6_data_window: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> prog_on);

  a_r6_byte_count: assert property (@(posedge clk) disable iff (!rst_n)
    prog_on && cmd_done |-> bytes_now == cmd_len);

  a_r7_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req && cmd_done && cmd_err) || (poll_req && poll_done && poll_err)
      |=> done && error && !cmd_req && !poll_req);

  a_r8_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !busy && (req_len == '0) |=> done && !error);
endmodule

bind page_prog_splitter psplit_checker #(
  .ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES)
) u_psplit_checker (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_len(req_len),
  .busy(busy), .done(done), .error(error),
  .cmd_req(cmd_req), .cmd_kind(cmd_kind), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
  .cmd_done(cmd_done), .cmd_err(cmd_err),
  .poll_req(poll_req), .poll_kind(poll_kind), .poll_done(poll_done), .poll_err(poll_err),
  .out_valid(out_valid), .out_ready(out_ready)
);

// File: tb/test_page_prog_splitter.sv
`timescale 1ns/1ps
module test_page_prog_splitter;
  localparam int AW = 8;
  localparam int LW = 8;
  localparam int DW = 8;
  localparam int PG = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [LW-1:0] req_len = '0;
  logic busy, done, error;
  logic cmd_req, cmd_kind;
  logic [AW-1:0] cmd_addr;
  logic [LW-1:0] cmd_len;
  logic cmd_done = 1'b0, cmd_err = 1'b0;
  logic poll_req, poll_kind;
  logic poll_done = 1'b0, poll_err = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic in_valid = 1'b0, in_ready;
  logic [DW-1:0] out_data;
  logic out_valid;
  logic out_ready = 1'b0;

  always #2.5 clk = ~clk;

  page_prog_splitter #(.ADDR_W(AW), .LEN_W(LW), .DATA_W(DW), .PAGE_BYTES(PG)) i_page_prog_splitter (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr), .req_len(req_len),
    .busy(busy), .done(done), .error(error),
    .cmd_req(cmd_req), .cmd_kind(cmd_kind), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
    .cmd_done(cmd_done), .cmd_err(cmd_err),
    .poll_req(poll_req), .poll_kind(poll_kind), .poll_done(poll_done), .poll_err(poll_err),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready)
  );

  int n_chk = 0, n_bad = 0;
  // event log: 0 write-enable, 1 latch wait, 2 program, 3 busy-clear wait
  int ev_kind [64];
  int ev_addr [64];
  int ev_len  [64];
  int ev_n = 0;
  int err_at = -1;
  int src = 0, rx_total = 0, rx_bad = 0, chunk_rx = 0;
  int cyc = 0;
  bit cseen = 0, pseen = 0;
  int cwait = 0, pwait = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // model of the sequencer, the poller, the data source and the sink
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      in_valid  = (cyc % 3) != 1;
      out_ready = (cyc % 5) != 2;
      in_data   = src[7:0];
      #1;
      if (cmd_req && !cmd_done && !cseen) begin
        if (ev_n < 64) begin
          ev_kind[ev_n] = cmd_kind ? 2 : 0;
          ev_addr[ev_n] = int'(cmd_addr);
          ev_len[ev_n]  = int'(cmd_len);
        end
        ev_n++;
        cseen = 1; cwait = 0; chunk_rx = 0;
      end
      if (poll_req && !poll_done && !pseen) begin
        if (ev_n < 64) begin
          ev_kind[ev_n] = poll_kind ? 3 : 1;
          ev_addr[ev_n] = 0;
          ev_len[ev_n]  = 0;
        end
        ev_n++;
        pseen = 1; pwait = 0;
      end
      if (in_valid && in_ready) src++;
      if (out_valid && out_ready) begin
        if (out_data != rx_total[7:0]) rx_bad++;
        rx_total++;
        chunk_rx++;
      end
      if (cmd_done) begin
        cmd_done = 0; cmd_err = 0;
      end else if (cmd_req) begin
        cwait++;
        if (cwait >= 2 && (!cmd_kind || chunk_rx == int'(cmd_len))) begin
          cmd_done = 1; cmd_err = (ev_n - 1 == err_at); cseen = 0;
        end
      end
      if (poll_done) begin
        poll_done = 0; poll_err = 0;
      end else if (poll_req) begin
        pwait++;
        if (pwait >= 3) begin
          poll_done = 1; poll_err = (ev_n - 1 == err_at); pseen = 0;
        end
      end
    end
  end

  task automatic run(input int a, input int l, input int inj, output int iters, output bit got_err);
    ev_n = 0; src = 0; rx_total = 0; rx_bad = 0; err_at = inj;
    got_err = 0; iters = 0;
    @(negedge clk);
    req_valid = 1; req_addr = AW'(a); req_len = LW'(l);
    for (int i = 1; i < 3000; i++) begin
      @(negedge clk);
      // R9: a second request while busy must be ignored
      if (i == 5) begin req_valid = 1; req_addr = 8'hA0; req_len = 8'd3; end
      else req_valid = 0;
      #2;
      if (done) begin iters = i; got_err = error; break; end
    end
    req_valid = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic check_split(input int a, input int l);
    int pos, e, k, c, room;
    pos = a; e = a + l; k = 0;
    while (pos < e) begin
      room = PG - (pos % PG);
      c = (e - pos < room) ? (e - pos) : room;
      chk(ev_kind[4*k] == 0 && ev_kind[4*k+1] == 1 && ev_kind[4*k+2] == 2 && ev_kind[4*k+3] == 3,
          "R4 step order", ev_kind[4*k+2], 2);
      if (k == 0) begin
        chk(ev_addr[2] == a, "R2 first address", ev_addr[2], a);
        chk(ev_len[2] == c, "R2 first length", ev_len[2], c);
      end else begin
        chk(ev_addr[4*k+2] == pos, "R3 chunk address", ev_addr[4*k+2], pos);
        chk(ev_len[4*k+2] == c, "R3 chunk length", ev_len[4*k+2], c);
      end
      chk(ev_len[4*k+2] > 0 && (ev_addr[4*k+2] % PG) + ev_len[4*k+2] <= PG,
          "R1 page bound", (ev_addr[4*k+2] % PG) + ev_len[4*k+2], PG);
      pos += c; k++;
    end
    chk(ev_n == 4 * k, "R3 command count", ev_n, 4 * k);
    chk(rx_total == l, "R6 byte total", rx_total, l);
    chk(rx_bad == 0, "R6 byte order", rx_bad, 0);
  endtask

  initial begin
    int it;
    bit ge;
    repeat (4) @(negedge clk);
    #2;
    chk(!busy && !done && !cmd_req && !poll_req && !out_valid && !in_ready, "R9 reset idle",
        int'(busy), 0);
    rst_n = 1;
    @(negedge clk);

    // R8: zero length
    run(7, 0, -1, it, ge);
    chk(it == 1, "R8 zero-length done cycle", it, 1);
    chk(!ge, "R8 zero-length error", int'(ge), 0);
    chk(ev_n == 0, "R8 zero-length commands", ev_n, 0);

    // sweep start offsets and lengths
    for (int a = 0; a < 18; a++) begin
      for (int l = 1; l < 36; l++) begin
        run(a, l, -1, it, ge);
        chk(it > 0 && !ge, "R9 done without error", int'(ge), 0);
        check_split(a, l);
      end
    end

    // R7: latch wait fails on the first chunk
    run(5, 40, 1, it, ge);
    chk(it > 0 && ge, "R7 latch failure error", int'(ge), 1);
    chk(ev_n == 2, "R7 latch failure stops", ev_n, 2);
    chk(rx_total == 0, "R7 latch failure no data", rx_total, 0);

    // R7: program command of the second chunk fails (chunks 11,16,13)
    run(5, 40, 6, it, ge);
    chk(it > 0 && ge, "R7 program failure error", int'(ge), 1);
    chk(ev_n == 7, "R7 program failure stops", ev_n, 7);
    chk(rx_total == 27, "R7 program failure bytes", rx_total, 27);

    // recovery after an error
    run(30, 20, -1, it, ge);
    chk(it > 0 && !ge, "R7 recovery after abort", int'(ge), 0);
    check_split(30, 20);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 190000);
    n_chk++; n_bad++;
    $display("FAIL R9 watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule